// File: doc/BRIEF.md
# Replayable Word FIFO with Level Flags

A single-clock first-in first-out buffer for 9-bit words, deep enough to hold 4096 of them. A producer pulses a write strobe to store a word and a consumer pulses a read strobe to take one out. Two internal pointers supply every storage address, so neither side handles addresses. The ninth data bit lets a parity bit travel with each 8-bit byte.

Three registered level flags report the fill state: nothing stored, completely filled, and holding at least half of the capacity. A write made while the buffer is filled is dropped, and a read made while it is empty is dropped, so stored data is never overwritten and the consumer never overtakes the producer. Read data is registered. It appears one cycle after an accepted read, and a valid pulse marks that cycle.

A replay input moves only the read side back to location zero. Everything written since reset can then be read out again, for example after a receiver reports an error, while the write side carries on from where it was. The occupancy is then reloaded from the write pointer. Replay is defined only while fewer than DEPTH words have been written since reset.

Top module: `fifo_rt_top`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers and the occupancy are cleared. After that edge `empty` is 1, and `full`, `half` and `dout_vld` are 0.
- R2: Words are read out in the order they were written. After a clock edge that accepts a read, `dout` holds the word and `dout_vld` is 1 for that one cycle. After any other edge `dout_vld` is 0.
- R3: `full` is 1 exactly when DEPTH words are stored. A write strobe with no read while `full` is 1 is ignored, and no stored word changes.
- R4: `empty` is 1 exactly when no word is stored. A read strobe while `empty` is 1 is ignored: `dout_vld` stays 0 and the read pointer does not move.
- R5: `half` is 1 exactly when DEPTH/2 or more words are stored (2048 at the default depth).
- R6: A read and a write in the same cycle both take effect and leave the occupancy unchanged. When the buffer is empty only the write takes effect. When it is full only the read takes effect.
- R7: A high `rexmit` sets the read pointer to location 0 and leaves the write pointer unchanged. The occupancy becomes the updated write pointer value. Later reads replay from the first word written since reset, and later writes append after the last stored word.
- R8: Both pointers wrap from DEPTH-1 to 0 with no loss or reordering of data.
- R9: A read strobe in the same cycle as `rexmit` is ignored: `dout_vld` is 0 after that edge. A write in that cycle still takes effect.
- R10: All 9 data bits are stored and returned unchanged, including bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rexmit | input | 1 | Replay: moves the read pointer back to 0 |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| dout_vld | output | 1 | High for the cycle after an accepted read |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half | output | 1 | At least DEPTH/2 words stored |

## Verification
The bench fills the buffer to its last word and strobes a write into it, which catches a design that overwrites the oldest word or lets the occupancy run past DEPTH. It reads an empty buffer and strobes read and write together on both an empty and a full buffer, where a wrong design would emit a stale word or move the count the wrong way. It checks the `half` threshold on both sides of DEPTH/2, drives the pointers across the wrap, and replays after partial reads. A design that also moved the write pointer on replay, or that honoured a read in the replay cycle, would return the wrong words or raise a spurious valid pulse.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic rt;
  } fifo_req_t;
endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  fifo_req_t     req,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count_nxt
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [CW-1:0] count;
  logic [AW-1:0] wr_nxt, rd_nxt;
  logic          is_full, is_empty;

  assign is_full  = (count == FULLC);
  assign is_empty = (count == '0);
  assign wr_acc   = req.wr && !is_full;
  assign rd_acc   = req.rd && !req.rt && !is_empty;

  always_comb begin
    wr_nxt = wr_ptr;
    if (wr_acc) wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    rd_nxt = rd_ptr;
    if (req.rt) rd_nxt = '0;
    else if (rd_acc) rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    if (req.rt) count_nxt = {1'b0, wr_nxt};
    else count_nxt = count + CW'(wr_acc) - CW'(rd_acc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      count  <= count_nxt;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    is_full && req.wr && !req.rd && !req.rt |=> $stable(wr_ptr) && count == FULLC);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    is_empty && req.rd && !req.rt |=> $stable(rd_ptr));
  a_r7_rewind_zero: assert property (@(posedge clk) disable iff (rst)
    req.rt |=> rd_ptr == '0);
  a_r6_both_keep_level: assert property (@(posedge clk) disable iff (rst)
    req.wr && req.rd && !req.rt && !is_full && !is_empty |=> $stable(count));
  a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULLC);
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW = 9,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvld
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvld <= 1'b0;
    else     rvld <= re;
  end

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    re |=> rvld);
  a_r2_no_valid_without_read: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvld);
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 4096,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      full  <= 1'b0;
      half  <= 1'b0;
    end else begin
      empty <= (count_nxt == '0);
      full  <= (count_nxt == FULLC);
      half  <= (count_nxt >= HALFC);
    end
  end

  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r5_full_implies_half: assert property (@(posedge clk) disable iff (rst)
    full |-> half);
endmodule

// File: rtl/fifo_rt_top.sv
module fifo_rt_top
  import fifo_rt_pkg::*;
#(
  parameter int DW = 9,
  parameter int DEPTH = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rexmit,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  fifo_req_t     req;
  logic          wr_acc, rd_acc;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_nxt;

  assign req = '{wr: wr_en, rd: rd_en, rt: rexmit};

  fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .req(req),
    .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count_nxt(count_nxt)
  );

  fifo_rt_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst),
    .we(wr_acc), .waddr(wr_ptr), .wdata(din),
    .re(rd_acc), .raddr(rd_ptr), .rdata(dout), .rvld(dout_vld)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .count_nxt(count_nxt),
    .empty(empty), .full(full), .half(half)
  );

  a_r9_rewind_blocks_read: assert property (@(posedge clk) disable iff (rst)
    rexmit |=> !dout_vld);
  a_r4_empty_read_silent: assert property (@(posedge clk) disable iff (rst)
    empty && !rexmit |=> !dout_vld);
endmodule

// File: tb/fifo_rt_top_test.sv
module fifo_rt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, rexmit = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_vld, empty, full, half;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cycles = 0;

  logic [DW-1:0] mdl [DEPTH];
  int unsigned mwp, mrp, mcnt, totw;

  fifo_rt_top #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rexmit(rexmit),
    .din(din), .dout(dout), .dout_vld(dout_vld),
    .empty(empty), .full(full), .half(half)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<200000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int unsigned nidx(int unsigned i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; rd_en = 0; rexmit = 0;
    @(posedge clk); @(posedge clk); #1;
    mwp = 0; mrp = 0; mcnt = 0; totw = 0;
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    check(full == 1'b0, "R1 full", int'(full), 0);
    check(half == 1'b0, "R1 half", int'(half), 0);
    check(dout_vld == 1'b0, "R1 dout_vld", int'(dout_vld), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(bit w, bit r, bit t, logic [DW-1:0] d, string tag);
    bit wacc, racc;
    logic [DW-1:0] expd;
    @(negedge clk);
    wr_en = w; rd_en = r; rexmit = t; din = d;
    wacc = w && (mcnt != DEPTH);
    racc = r && !t && (mcnt != 0);
    expd = mdl[mrp];
    @(posedge clk); #1;
    if (wacc) begin mdl[mwp] = d; mwp = nidx(mwp); totw++; end
    if (t) begin
      mrp = 0; mcnt = mwp;
    end else begin
      if (racc) mrp = nidx(mrp);
      mcnt = mcnt + int'(wacc) - int'(racc);
    end
    check(dout_vld == racc, {tag, " R2 dout_vld"}, int'(dout_vld), int'(racc));
    if (racc) check(dout == expd, {tag, " R2 dout"}, int'(dout), int'(expd));
    check(empty == (mcnt == 0), "R4 empty", int'(empty), int'(mcnt == 0));
    check(full == (mcnt == DEPTH), "R3 full", int'(full), int'(mcnt == DEPTH));
    check(half == (mcnt >= DEPTH / 2), "R5 half", int'(half), int'(mcnt >= DEPTH / 2));
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; rexmit = 0;
  endtask

  initial begin
    do_reset();

    // R4: read from an empty buffer is dropped
    step(0, 1, 0, '0, "R4");
    check(dout_vld == 1'b0, "R4 empty read valid", int'(dout_vld), 0);

    // R10: bit 8 and edge patterns survive storage
    step(1, 0, 0, 9'h1FF, "R10");
    step(1, 0, 0, 9'h100, "R10");
    step(1, 0, 0, 9'h0AA, "R10");
    step(1, 0, 0, 9'h155, "R10");
    step(0, 1, 0, '0, "R10");
    check(dout == 9'h1FF, "R10 bit8 all ones", int'(dout), 'h1FF);
    step(0, 1, 0, '0, "R10");
    check(dout == 9'h100, "R10 bit8 only", int'(dout), 'h100);
    step(0, 1, 0, '0, "R10");
    step(0, 1, 0, '0, "R10");

    // R6: read and write together on an empty buffer: only the write lands
    step(1, 1, 0, 9'h033, "R6");
    check(empty == 1'b0, "R6 empty rd+wr write lands", int'(empty), 0);
    check(dout_vld == 1'b0, "R6 empty rd+wr no read", int'(dout_vld), 0);
    step(1, 0, 0, 9'h044, "R6");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 9'(i + 'h60), "R6");
    while (mcnt != 0) step(0, 1, 0, '0, "R6");

    // R7 / R9: replay after partial reads
    do_reset();
    for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(i * 7 + 3), "R7");
    for (int i = 0; i < 6; i++) step(0, 1, 0, '0, "R7");
    step(0, 1, 1, '0, "R9");
    check(dout_vld == 1'b0, "R9 read in replay cycle", int'(dout_vld), 0);
    check(mcnt == 10, "R7 model level", int'(mcnt), 10);
    step(0, 1, 0, '0, "R7");
    check(dout == 9'd3, "R7 first replayed word", int'(dout), 3);
    step(1, 0, 1, 9'h1A5, "R7");
    step(1, 0, 0, 9'h0C3, "R7");
    while (mcnt != 0) step(0, 1, 0, '0, "R7");
    check(dout == 9'h0C3, "R7 append after replay", int'(dout), 'h0C3);

    // R3 / R5: fill to the last word
    do_reset();
    for (int i = 0; i < DEPTH / 2 - 1; i++) step(1, 0, 0, 9'(i ^ (i >> 3)), "R5");
    check(half == 1'b0, "R5 half below threshold", int'(half), 0);
    step(1, 0, 0, 9'h1E1, "R5");
    check(half == 1'b1, "R5 half at threshold", int'(half), 1);
    while (mcnt != DEPTH) step(1, 0, 0, 9'(mwp * 5), "R3");
    check(full == 1'b1, "R3 full at depth", int'(full), 1);
    step(1, 0, 0, 9'h0EE, "R3");
    check(full == 1'b1, "R3 write while full ignored", int'(full), 1);
    step(1, 1, 0, 9'h0DD, "R6");
    check(full == 1'b0, "R6 full rd+wr only read", int'(full), 0);
    step(1, 0, 0, 9'h0BB, "R8");
    // R8: drain across the wrap of both pointers
    while (mcnt != 0) step(0, 1, 0, '0, "R8");
    check(dout == 9'h0BB, "R8 last word after wrap", int'(dout), 'h0BB);

    // R8 / R2: random traffic past the wrap, no replay
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 12000; i++) begin
      bit w, r;
      w = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      step(w, r, 0, 9'($urandom), "R8");
    end

    // R7 / R9: random traffic with replay while fewer than DEPTH written
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      bit w, r, t;
      w = ($urandom % 2) != 0;
      r = ($urandom % 2) != 0;
      t = (($urandom % 64) == 0) && (totw + 1 < DEPTH);
      step(w, r, t, 9'($urandom), "R7");
    end
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule